// File: doc/BRIEF.md
# Dual-Mode Registered Bus Driver

This block is a 12-bit one-way bus driver. It has two data paths and a path select chooses between them. In the registered path, each output bit shows the value that a flip-flop captured on a rising clock edge. In the bypass path, the input word goes to the outputs with no clock delay. Each data bit feeds two identical output buses, so one input word drives 24 lines.

Loading is controlled by an active-low load strobe, and that strobe covers only part of the word. When the strobe is low, every bit captures its input. When the strobe is high, only the top four bits capture; the lower eight bits keep their stored values. The register captures on every clock edge in either path, so the path select affects only what reaches the outputs.

High impedance is not built from internal tristate nets. Each output bus has its own enable flag, and an outer pad ring can use that flag to drive or release the lines. One active-low output enable controls both buses. When it is released, the data lines carry zero and both flags go low. A synchronous active-high reset clears the stored word.

Top module: `dual_mode_bus_driver`

## Requirements
- R1: On a rising clock edge with `rst` high, all stored bits become zero; afterwards the registered path presents 12'h000.
- R2: With `bypass_sel` low (0 = registered path), the outputs show the word captured at the most recent clock edge. They do not follow changes on `a_in` between edges.
- R3: With `bypass_sel` high (1 = bypass path), the outputs equal `a_in` in the same cycle, with no clock delay.
- R4: On a rising edge with `load_n` low, all 12 bits of `a_in` are stored.
- R5: On a rising edge with `load_n` high, bits 11..8 of `a_in` are stored and bits 7..0 keep their previous values.
- R6: `y_a` and `y_b` always carry the same data, and `y_a_en` always equals `y_b_en`.
- R7: With `oe_n` high, both data buses read zero and both enable flags are low. With `oe_n` low, both enable flags are high and the buses carry the selected path.
- R8: The register keeps capturing while the bypass path is selected. Returning to the registered path shows the word captured at the last edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the stored word |
| a_in | input | 12 | Input data word |
| bypass_sel | input | 1 | Path select: 0 registered, 1 bypass |
| load_n | input | 1 | Active-low load strobe for bits 7..0 (bits 11..8 load on every edge) |
| oe_n | input | 1 | Active-low output enable for both buses |
| y_a | output | 12 | First output copy |
| y_a_en | output | 1 | Drive flag for `y_a` (1 = driven, 0 = high impedance) |
| y_b | output | 12 | Second output copy |
| y_b_en | output | 1 | Drive flag for `y_b` |

## Verification
The main target is the split strobe. The bench runs edges with `load_n` high on words where the upper and lower halves differ from the stored value. A design that gates the whole word would freeze the upper nibble. A design that ignores the strobe would overwrite the lower byte. The bench changes `a_in` between edges in registered mode, which catches a path select wired the wrong way round or a register clocked off the wrong edge. It also loads new words while the bypass path is selected and then switches back, which exposes capture logic that wrongly depends on the path select. Finally, it toggles the output enable on non-zero data, which catches enable flags that do not drop and buses that do not return to zero.

// File: rtl/drv_pkg.sv
package drv_pkg;
  localparam int DRV_WIDTH_DEFAULT = 12;
  localparam int DRV_GATED_DEFAULT = 8;
  localparam int DRV_COPIES        = 2;

  typedef enum logic {
    PATH_REG    = 1'b0,
    PATH_BYPASS = 1'b1
  } path_e;
endpackage

// File: rtl/drv_capture_reg.sv
module drv_capture_reg #(
  parameter int WIDTH      = 12,
  parameter int GATED_BITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] FREE_MASK = {WIDTH{1'b1}} << GATED_BITS;

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_next;

  generate
    if (GATED_BITS == 0) begin : g_plain
      always_comb q_next = d;
    end else begin : g_split
      // lower bits obey the strobe, upper bits load on every edge
      always_comb begin
        if (load_n) q_next = (q_r & ~FREE_MASK) | (d & FREE_MASK);
        else        q_next = d;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= q_next;
  end

  assign q = q_r;
endmodule

// File: rtl/drv_path_mux.sv
module drv_path_mux
  import drv_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  path_e            path,
  input  logic [WIDTH-1:0] stored,
  input  logic [WIDTH-1:0] direct,
  output logic [WIDTH-1:0] sel
);
  always_comb begin
    unique case (path)
      PATH_BYPASS: sel = direct;
      default:     sel = stored;
    endcase
  end
endmodule

// File: rtl/drv_out_gate.sv
module drv_out_gate #(
  parameter int WIDTH = 12
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             drive
);
  always_comb begin
    drive = ~oe_n;
    dout  = oe_n ? '0 : din;
  end
endmodule

// File: rtl/dual_mode_bus_driver.sv
module dual_mode_bus_driver
  import drv_pkg::*;
#(
  parameter int WIDTH      = DRV_WIDTH_DEFAULT,
  parameter int GATED_BITS = DRV_GATED_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic             bypass_sel,
  input  logic             load_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] y_a,
  output logic             y_a_en,
  output logic [WIDTH-1:0] y_b,
  output logic             y_b_en
);
  logic [WIDTH-1:0] stored_w;
  logic [WIDTH-1:0] sel_w;
  logic [WIDTH-1:0] copy_d [DRV_COPIES];
  logic             copy_en[DRV_COPIES];
  path_e            path_w;

  assign path_w = bypass_sel ? PATH_BYPASS : PATH_REG;

  drv_capture_reg #(.WIDTH(WIDTH), .GATED_BITS(GATED_BITS)) u_reg (
    .clk(clk), .rst(rst), .load_n(load_n), .d(a_in), .q(stored_w)
  );

  drv_path_mux #(.WIDTH(WIDTH)) u_mux (
    .path(path_w), .stored(stored_w), .direct(a_in), .sel(sel_w)
  );

  generate
    for (genvar c = 0; c < DRV_COPIES; c++) begin : g_copy
      drv_out_gate #(.WIDTH(WIDTH)) u_gate (
        .oe_n(oe_n), .din(sel_w), .dout(copy_d[c]), .drive(copy_en[c])
      );
    end
  endgenerate

  assign y_a    = copy_d[0];
  assign y_a_en = copy_en[0];
  assign y_b    = copy_d[1];
  assign y_b_en = copy_en[1];
endmodule

// File: rtl/drv_checker.sv
module drv_checker #(
  parameter int WIDTH      = 12,
  parameter int GATED_BITS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic             bypass_sel,
  input logic             load_n,
  input logic             oe_n,
  input logic [WIDTH-1:0] y_a,
  input logic             y_a_en,
  input logic [WIDTH-1:0] y_b,
  input logic             y_b_en
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !bypass_sel && !oe_n) |-> (y_a == '0)); // R1

  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_n) && !bypass_sel && !oe_n)
      |-> (y_a == $past(a_in))); // R4

  AST_SPLIT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_n) && !bypass_sel && !oe_n
      && !$past(bypass_sel) && !$past(oe_n))
      |-> (y_a[WIDTH-1:GATED_BITS] == $past(a_in[WIDTH-1:GATED_BITS])
           && y_a[GATED_BITS-1:0] == $past(y_a[GATED_BITS-1:0]))); // R5

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    (bypass_sel && !oe_n) |-> (y_a == a_in)); // R3

  AST_COPIES_MATCH: assert property (@(posedge clk) disable iff (rst)
    (y_a == y_b) && (y_a_en == y_b_en)); // R6

  AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (y_a == '0 && !y_a_en && !y_b_en)); // R7

  AST_ENABLED_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (y_a_en && y_b_en)); // R7
endmodule

bind dual_mode_bus_driver drv_checker #(.WIDTH(WIDTH), .GATED_BITS(GATED_BITS)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .bypass_sel(bypass_sel), .load_n(load_n),
  .oe_n(oe_n), .y_a(y_a), .y_a_en(y_a_en), .y_b(y_b), .y_b_en(y_b_en)
);

// File: tb/sim_dual_mode_bus_driver.sv
`timescale 1ns/1ps
module sim_dual_mode_bus_driver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] a_in = '0;
  logic        bypass_sel = 1'b0;
  logic        load_n = 1'b0;
  logic        oe_n = 1'b0;
  logic [11:0] y_a, y_b;
  logic        y_a_en, y_b_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [11:0] model = '0;

  always #5 clk = ~clk;

  dual_mode_bus_driver u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .bypass_sel(bypass_sel),
    .load_n(load_n), .oe_n(oe_n), .y_a(y_a), .y_a_en(y_a_en),
    .y_b(y_b), .y_b_en(y_b_en)
  );

  // one cycle: drive at negedge, compare, then advance the model at posedge
  task automatic step(input logic [11:0] a, input logic byp, input logic ldn,
                      input logic oen, input logic r, input string tag);
    logic [11:0] exp_d;
    logic        exp_en;
    @(negedge clk);
    a_in = a; bypass_sel = byp; load_n = ldn; oe_n = oen; rst = r;
    #1;
    exp_en = !oen;
    exp_d  = oen ? 12'h000 : (byp ? a : model);
    checks++;
    if (y_a !== exp_d || y_b !== exp_d || y_a_en !== exp_en || y_b_en !== exp_en) begin
      fails++;
      $display("FAIL %s: y_a=%h y_b=%h en=%b/%b expected data=%h en=%b",
               tag, y_a, y_b, y_a_en, y_b_en, exp_d, exp_en);
    end
    @(posedge clk);
    if (r)          model = 12'h000;
    else if (!ldn)  model = a;
    else            model = {a[11:8], model[7:0]};
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(12'hFFF, 1'b0, 1'b0, 1'b1, 1'b1, "R7 released during reset");
    step(12'hABC, 1'b0, 1'b0, 1'b0, 1'b1, "R1 reset cycle");
    step(12'h5A5, 1'b0, 1'b1, 1'b0, 1'b0, "R1 zero after reset");
    // full loads, data changes between edges
    step(12'h123, 1'b0, 1'b0, 1'b0, 1'b0, "R4 full load");
    step(12'hFED, 1'b0, 1'b0, 1'b0, 1'b0, "R2 holds captured word");
    step(12'h0F0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 full load second");
    step(12'h0F0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 R6 registered copies");
    // split strobe
    step(12'hA55, 1'b0, 1'b1, 1'b0, 1'b0, "R5 upper loads lower holds");
    step(12'h3CC, 1'b0, 1'b1, 1'b0, 1'b0, "R5 lower byte kept");
    step(12'h7FF, 1'b0, 1'b1, 1'b0, 1'b0, "R5 repeat split");
    step(12'h000, 1'b0, 1'b0, 1'b0, 1'b0, "R5 split result visible");
    step(12'h999, 1'b0, 1'b0, 1'b0, 1'b0, "R4 clear via full load");
    // bypass path
    step(12'h6B2, 1'b1, 1'b0, 1'b0, 1'b0, "R3 bypass passes input");
    step(12'h14E, 1'b1, 1'b1, 1'b0, 1'b0, "R3 bypass with strobe high");
    step(12'hC0D, 1'b1, 1'b0, 1'b0, 1'b0, "R8 capture while bypassed");
    step(12'h222, 1'b0, 1'b1, 1'b0, 1'b0, "R8 back to registered path");
    step(12'h222, 1'b0, 1'b0, 1'b0, 1'b0, "R8 R5 split in follow-up");
    // output enable
    step(12'hFFF, 1'b0, 1'b0, 1'b1, 1'b0, "R7 released registered");
    step(12'hEEE, 1'b1, 1'b0, 1'b1, 1'b0, "R7 released bypass");
    step(12'hEEE, 1'b0, 1'b1, 1'b0, 1'b0, "R7 re-enabled shows stored");
    step(12'h5A5, 1'b1, 1'b1, 1'b0, 1'b0, "R6 R3 copies in bypass");
    for (int i = 0; i < 16; i++) begin
      step(12'(i * 12'h111 + 12'h035), 1'(i[0]), 1'(i[1]), 1'(i == 9), 1'b0,
           "R2 R3 R5 mixed sweep");
    end
    step(12'h3C3, 1'b0, 1'b0, 1'b0, 1'b1, "R1 reset mid-run");
    step(12'h777, 1'b0, 1'b1, 1'b0, 1'b0, "R1 cleared after mid reset");
    step(12'h777, 1'b0, 1'b0, 1'b0, 1'b0, "R5 after reset low byte zero");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule